// File: doc/BRIEF.md
# Control-Word Steered Register/ALU/Shifter Datapath

This block is the execution datapath of a small 16-bit processor. Every clock cycle a single packed 16-bit control word tells it which registers to read, which arithmetic or logic function to apply, how to shift the result, whether to store a value and from where, and whether to drive the result onto the output port. Four general registers feed two independently enabled read buses. These buses go into an eight-function ALU, whose result passes through a four-function shifter.

The stored value is either the external input word or the shifter result. Zero and negative status flags are taken from the ALU result on every cycle that writes a register. A controller outside this block produces the control words. Instruction fetch, decoding and sequencing happen there.

Top module: `dp_core`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, all four registers and both status flags are cleared to 0.
- R2: When the write-enable field is 1, the selected write data is stored at the rising edge into the register whose 2-bit code (00 to 11) is in the write-address field. The other registers are unchanged.
- R3: When the write-enable field is 0, no register and neither flag changes at the edge, whatever the other fields hold.
- R4: Read ports A and B each select any register by their own 2-bit address and are combinational. Both ports may select the same register at once.
- R5: A read port whose enable field is 0 presents all zeros to the ALU, whatever its address.
- R6: Write data is the external input word when the input-select field is 1, and the shifter result when it is 0.
- R7: ALU codes 000, 001, 010 and 011 give A, A AND B, A OR B and NOT A respectively.
- R8: ALU codes 100, 101, 110 and 111 give A+B, A-B, A+1 and A-1 respectively, all wrapping modulo 2^16.
- R9: Shifter code 00 passes the ALU result through. Code 01 shifts it left one place with a 0 entering bit 0. Code 10 shifts it right one place with a 0 entering bit 15. Code 11 rotates it right one place, so bit 0 moves to bit 15.
- R10: At each edge with write enable 1, `flag_z` takes 1 if the ALU result (before the shifter) is zero, and `flag_n` takes bit 15 of that ALU result.
- R11: `out_port` carries the shifter result while the output-enable field is 1, and is high-impedance otherwise.
- R12: The control word's fields run from bit 15 down as follows: input select [15], write enable [14], write address [13:12], A enable [11], A address [10:9], B enable [8], B address [7:6], ALU code [5:3], shifter code [2:1], output enable [0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl | input | 16 | Packed control word for this cycle |
| in_port | input | 16 | External input data word |
| out_port | output | 16 | Shifter result, tri-stated when output enable is 0 |
| flag_z | output | 1 | Registered zero flag |
| flag_n | output | 1 | Registered negative flag |

## Verification
`out_port` depends only on the current control word and the register contents, so it is due in the same cycle the control word is applied. The bench drives each word at the falling edge and samples `out_port` 2 ns later, before the next rising edge.

Register writes and flag updates appear one rising edge after the word that requests them. The bench therefore checks stored values with a later read-back word, applied at a following falling edge. It checks the flags at that same later point.

With output enable at 0, the bench observes the port through a pull-up on its side, so a released port reads as all ones.

// File: rtl/dp_pkg.sv
// Package dp_pkg
// Shared types for the control-word datapath: operation codes and the
// packed control word layout. Assumes a 16-bit control word.
package dp_pkg;

    localparam int CTRL_W = 16;

    // ALU function codes (R7, R8)
    typedef enum logic [2:0] {
        ALU_PASS = 3'b000,
        ALU_AND  = 3'b001,
        ALU_OR   = 3'b010,
        ALU_NOTA = 3'b011,
        ALU_ADD  = 3'b100,
        ALU_SUB  = 3'b101,
        ALU_INC  = 3'b110,
        ALU_DEC  = 3'b111
    } alu_op_e;

    // Shifter function codes (R9)
    typedef enum logic [1:0] {
        SHF_PASS = 2'b00,
        SHF_SHL  = 2'b01,
        SHF_SHR  = 2'b10,
        SHF_ROR  = 2'b11
    } shf_op_e;

    // Control word, most significant field first (R12)
    typedef struct packed {
        logic       src_ext;   // 1: external input, 0: shifter result
        logic       wr_en;
        logic [1:0] wr_sel;
        logic       pa_en;
        logic [1:0] pa_sel;
        logic       pb_en;
        logic [1:0] pb_sel;
        alu_op_e    alu_fn;
        shf_op_e    shf_fn;
        logic       drive_en;
    } ctrl_t;

endpackage

// File: rtl/dp_regfile.sv
// Module dp_regfile
// Register bank with one synchronous write port and two combinational
// read ports, each read port gated by its own enable (disabled -> zero).
// Assumes NREG is a power of two; reset is synchronous, active low.
module dp_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 4,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_sel,
    input  logic [DW-1:0]       wr_data,
    input  logic                pa_en,
    input  logic [AW-1:0]       pa_sel,
    input  logic                pb_en,
    input  logic [AW-1:0]       pb_sel,
    output logic [DW-1:0]       pa_data,
    output logic [DW-1:0]       pb_data,
    output logic [NREG*DW-1:0]  bank_flat
);

    // One storage register per slot, each with its own write decode
    for (genvar gi = 0; gi < NREG; gi++) begin : g_slot
        logic [DW-1:0] slot_q;

        // Purpose: clear on reset, load when this slot is addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en && (wr_sel == AW'(gi))) begin
                slot_q <= wr_data;
            end
        end

        assign bank_flat[gi*DW +: DW] = slot_q;
    end

    // Purpose: read port A, forced to zero when disabled
    always_comb begin
        pa_data = '0;
        if (pa_en) begin
            pa_data = bank_flat[pa_sel*DW +: DW];
        end
    end

    // Purpose: read port B, forced to zero when disabled
    always_comb begin
        pb_data = '0;
        if (pb_en) begin
            pb_data = bank_flat[pb_sel*DW +: DW];
        end
    end

endmodule

// File: rtl/dp_alu.sv
// Module dp_alu
// Eight-function combinational ALU on two operands. Arithmetic wraps
// modulo 2^DW; no carry or overflow is produced.
module dp_alu
    import dp_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_op_e        fn,
    input  logic [DW-1:0]  opa,
    input  logic [DW-1:0]  opb,
    output logic [DW-1:0]  res
);

    localparam logic [DW-1:0] ONE = DW'(1);

    // Purpose: select the ALU function
    always_comb begin
        unique case (fn)
            ALU_PASS: res = opa;
            ALU_AND:  res = opa & opb;
            ALU_OR:   res = opa | opb;
            ALU_NOTA: res = ~opa;
            ALU_ADD:  res = opa + opb;
            ALU_SUB:  res = opa - opb;
            ALU_INC:  res = opa + ONE;
            ALU_DEC:  res = opa - ONE;
            default:  res = opa;
        endcase
    end

endmodule

// File: rtl/dp_shifter.sv
// Module dp_shifter
// Single-place shifter after the ALU: pass, logical left, logical right,
// rotate right. Purely combinational.
module dp_shifter
    import dp_pkg::*;
#(
    parameter int DW = 16
) (
    input  shf_op_e        fn,
    input  logic [DW-1:0]  din,
    output logic [DW-1:0]  dout
);

    // Purpose: select the shift function
    always_comb begin
        unique case (fn)
            SHF_PASS: dout = din;
            SHF_SHL:  dout = {din[DW-2:0], 1'b0};
            SHF_SHR:  dout = {1'b0, din[DW-1:1]};
            SHF_ROR:  dout = {din[0], din[DW-1:1]};
            default:  dout = din;
        endcase
    end

endmodule

// File: rtl/dp_status.sv
// Module dp_status
// Zero and negative flags taken from the ALU result, captured only on
// cycles that write a register. Synchronous active-low reset clears both.
module dp_status #(
    parameter int DW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           capture,
    input  logic [DW-1:0]  alu_res,
    output logic           zero_q,
    output logic           neg_q
);

    // Purpose: update both flags on write cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_q <= 1'b0;
            neg_q  <= 1'b0;
        end else if (capture) begin
            zero_q <= (alu_res == '0);
            neg_q  <= alu_res[DW-1];
        end
    end

endmodule

// File: rtl/dp_core.sv
// Module dp_core
// Top of the datapath. Unpacks the control word, connects register bank,
// ALU, shifter and flags, selects write data and drives the tri-stated
// output port. Assumes a controller supplies one word per cycle.
module dp_core
    import dp_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CTRL_W-1:0]    ctrl,
    input  logic [DW-1:0]        in_port,
    output logic [DW-1:0]        out_port,
    output logic                 flag_z,
    output logic                 flag_n
);

    ctrl_t                cw;
    logic [DW-1:0]        a_bus;
    logic [DW-1:0]        b_bus;
    logic [DW-1:0]        alu_y;
    logic [DW-1:0]        shf_y;
    logic [DW-1:0]        wr_data;
    logic [NREG*DW-1:0]   bank_flat;

    assign cw = ctrl_t'(ctrl);

    // Write source: external word or shifter result
    assign wr_data = cw.src_ext ? in_port : shf_y;

    dp_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cw.wr_en),
        .wr_sel    (cw.wr_sel),
        .wr_data   (wr_data),
        .pa_en     (cw.pa_en),
        .pa_sel    (cw.pa_sel),
        .pb_en     (cw.pb_en),
        .pb_sel    (cw.pb_sel),
        .pa_data   (a_bus),
        .pb_data   (b_bus),
        .bank_flat (bank_flat)
    );

    dp_alu #(.DW(DW)) u_alu (
        .fn  (cw.alu_fn),
        .opa (a_bus),
        .opb (b_bus),
        .res (alu_y)
    );

    dp_shifter #(.DW(DW)) u_shf (
        .fn   (cw.shf_fn),
        .din  (alu_y),
        .dout (shf_y)
    );

    dp_status #(.DW(DW)) u_st (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cw.wr_en),
        .alu_res (alu_y),
        .zero_q  (flag_z),
        .neg_q   (flag_n)
    );

    // Output port released when not enabled
    assign out_port = cw.drive_en ? shf_y : 'z;

endmodule

// File: rtl/dp_core_chk.sv
// Module dp_core_chk
// Property checker for dp_core, attached by bind. Observes the control
// word, the read buses, the ALU result, the register bank and the flags.
module dp_core_chk
    import dp_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CTRL_W-1:0]   ctrl,
    input logic [DW-1:0]       in_port,
    input logic [DW-1:0]       a_bus,
    input logic [DW-1:0]       b_bus,
    input logic [DW-1:0]       alu_y,
    input logic [NREG*DW-1:0]  bank_flat,
    input logic                flag_z,
    input logic                flag_n
);

    ctrl_t cw;
    assign cw = ctrl_t'(ctrl);

    function automatic logic [DW-1:0] slot(input logic [NREG*DW-1:0] f,
                                           input logic [1:0] idx);
        return f[idx*DW +: DW];
    endfunction

    p_reset_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bank_flat == '0) && !flag_z && !flag_n);

    p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cw.wr_en |=> $stable(bank_flat) && $stable(flag_z) && $stable(flag_n));

    p_ext_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.wr_en && cw.src_ext) |=>
            slot(bank_flat, $past(cw.wr_sel)) == $past(in_port));

    p_port_a_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cw.pa_en |-> a_bus == '0);

    p_port_b_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cw.pb_en |-> b_bus == '0);

    p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cw.wr_en |=> flag_z == ($past(alu_y) == '0));

    p_neg_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cw.wr_en |=> flag_n == $past(alu_y[DW-1]));

endmodule

bind dp_core dp_core_chk #(.DW(DW), .NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .in_port   (in_port),
    .a_bus     (a_bus),
    .b_bus     (b_bus),
    .alu_y     (alu_y),
    .bank_flat (bank_flat),
    .flag_z    (flag_z),
    .flag_n    (flag_n)
);

// File: tb/dp_core_bench.sv
// Directed bench for dp_core. A shadow model built from the requirements
// predicts every result; one task per scenario checks its own results.
module dp_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ctrl = '0;
    logic [15:0] in_port = '0;
    wire  [15:0] out_w;
    logic        flag_z;
    logic        flag_n;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m [4];
    logic        mz, mn;
    logic [15:0] exp_out;

    always #5 clk = ~clk;

    dp_core u_dp_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl),
        .in_port  (in_port),
        .out_port (out_w),
        .flag_z   (flag_z),
        .flag_n   (flag_n)
    );

    // Released port reads as all ones through these pull-ups (R11)
    for (genvar gi = 0; gi < 16; gi++) begin : g_pu
        pullup pu (out_w[gi]);
    end

    // Control word packing per R12
    function automatic logic [15:0] cw(input logic src, input logic we,
            input logic [1:0] wa, input logic ae, input logic [1:0] aa,
            input logic be, input logic [1:0] ba, input logic [2:0] fn,
            input logic [1:0] sh, input logic oe);
        return {src, we, wa, ae, aa, be, ba, fn, sh, oe};
    endfunction

    function automatic logic [15:0] alu_m(input logic [2:0] fn,
            input logic [15:0] a, input logic [15:0] b);
        case (fn)
            3'b000: return a;
            3'b001: return a & b;
            3'b010: return a | b;
            3'b011: return ~a;
            3'b100: return 16'((32'(a) + 32'(b)) % 65536);
            3'b101: return 16'((32'(a) + 65536 - 32'(b)) % 65536);
            3'b110: return 16'((32'(a) + 1) % 65536);
            default: return 16'((32'(a) + 65535) % 65536);
        endcase
    endfunction

    function automatic logic [15:0] shf_m(input logic [1:0] sh,
            input logic [15:0] v);
        case (sh)
            2'b00: return v;
            2'b01: return v << 1;
            2'b10: return v >> 1;
            default: return {v[0], v[15:1]};
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act,
            input logic [15:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Apply one word at the falling edge, predict its results
    task automatic cyc(input logic [15:0] w, input logic [15:0] d);
        logic [15:0] a, b, y, s;
        @(negedge clk);
        ctrl = w;
        in_port = d;
        #2;
        a = w[11] ? m[w[10:9]] : 16'h0000;
        b = w[8]  ? m[w[7:6]]  : 16'h0000;
        y = alu_m(w[5:3], a, b);
        s = shf_m(w[2:1], y);
        exp_out = w[0] ? s : 16'hFFFF;
        if (w[14]) begin
            m[w[13:12]] = w[15] ? d : s;
            mz = (y == 16'h0000);
            mn = y[15];
        end
    endtask

    task automatic rd(input int idx, input string tag);
        cyc(cw(0, 0, 2'(idx), 1, 2'(idx), 0, 0, 3'b000, 2'b00, 1), 16'h0000);
        chk(tag, out_w, exp_out);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ctrl = '0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) m[i] = 16'h0000;
        mz = 1'b0;
        mn = 1'b0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) rd(i, "R1 register cleared");
        chk("R1 zero flag cleared", {15'h0, flag_z}, 16'h0);
        chk("R1 neg flag cleared", {15'h0, flag_n}, 16'h0);
    endtask

    task automatic t_load();
        logic [15:0] vals [4];
        vals[0] = 16'h1234; vals[1] = 16'h00F0;
        vals[2] = 16'h8001; vals[3] = 16'hFFFF;
        for (int i = 0; i < 4; i++)
            cyc(cw(1, 1, 2'(i), 0, 0, 0, 0, 3'b000, 2'b00, 0), vals[i]);
        for (int i = 0; i < 4; i++) rd(i, "R2/R6 external load");
    endtask

    task automatic t_we_low();
        cyc(cw(1, 0, 2'd2, 1, 2'd3, 0, 0, 3'b110, 2'b00, 0), 16'h5555);
        rd(2, "R3 no write when disabled");
        chk("R3 zero flag held", {15'h0, flag_z}, {15'h0, mz});
        chk("R3 neg flag held", {15'h0, flag_n}, {15'h0, mn});
    endtask

    task automatic t_ports();
        cyc(cw(0, 0, 0, 1, 2'd1, 1, 2'd1, 3'b001, 2'b00, 1), 0);
        chk("R4 same register twice AND", out_w, exp_out);
        cyc(cw(0, 0, 0, 1, 2'd3, 1, 2'd0, 3'b101, 2'b00, 1), 0);
        chk("R4 A=R3 B=R0 subtract", out_w, exp_out);
        cyc(cw(0, 0, 0, 1, 2'd0, 1, 2'd3, 3'b101, 2'b00, 1), 0);
        chk("R4 A=R0 B=R3 subtract", out_w, exp_out);
    endtask

    task automatic t_port_off();
        cyc(cw(0, 0, 0, 0, 2'd0, 1, 2'd2, 3'b000, 2'b00, 1), 0);
        chk("R5 A disabled gives zero", out_w, 16'h0000);
        cyc(cw(0, 0, 0, 1, 2'd2, 0, 2'd3, 3'b100, 2'b00, 1), 0);
        chk("R5 B disabled adds zero", out_w, 16'h8001);
    endtask

    task automatic t_alu();
        for (int f = 0; f < 8; f++) begin
            cyc(cw(0, 0, 0, 1, 2'd2, 1, 2'd1, 3'(f), 2'b00, 1), 0);
            chk(f < 4 ? "R7 logic op A=8001" : "R8 arith op A=8001", out_w, exp_out);
            cyc(cw(0, 0, 0, 1, 2'd3, 1, 2'd0, 3'(f), 2'b00, 1), 0);
            chk(f < 4 ? "R7 logic op A=FFFF" : "R8 arith op A=FFFF wrap", out_w, exp_out);
        end
        cyc(cw(0, 0, 0, 0, 0, 0, 0, 3'b111, 2'b00, 1), 0);
        chk("R8 zero minus one wraps", out_w, 16'hFFFF);
    endtask

    task automatic t_shift();
        for (int s = 0; s < 4; s++) begin
            cyc(cw(0, 0, 0, 1, 2'd2, 0, 0, 3'b000, 2'(s), 1), 0);
            chk("R9 shift on 8001", out_w, exp_out);
            cyc(cw(0, 0, 0, 1, 2'd0, 0, 0, 3'b000, 2'(s), 1), 0);
            chk("R9 shift on 1234", out_w, exp_out);
        end
    endtask

    task automatic t_shf_write();
        cyc(cw(0, 1, 2'd1, 1, 2'd2, 0, 0, 3'b000, 2'b11, 0), 16'hAAAA);
        rd(1, "R6 shifter result written");
        chk("R6 expected value", m[1], 16'hC000);
    endtask

    task automatic t_flags();
        cyc(cw(0, 1, 2'd0, 1, 2'd3, 1, 2'd3, 3'b101, 2'b00, 0), 0);
        cyc(cw(0, 0, 0, 0, 0, 0, 0, 3'b000, 2'b00, 0), 0);
        chk("R10 zero result sets Z", {15'h0, flag_z}, 16'h1);
        chk("R10 zero result clears N", {15'h0, flag_n}, 16'h0);
        cyc(cw(0, 1, 2'd0, 1, 2'd1, 0, 0, 3'b000, 2'b01, 0), 0);
        cyc(cw(0, 0, 0, 0, 0, 0, 0, 3'b000, 2'b00, 0), 0);
        chk("R10 N from ALU not shifter", {15'h0, flag_n}, 16'h1);
        chk("R10 Z from ALU not shifter", {15'h0, flag_z}, 16'h0);
        cyc(cw(1, 1, 2'd2, 1, 2'd3, 0, 0, 3'b110, 2'b00, 0), 16'h0007);
        cyc(cw(0, 0, 0, 0, 0, 0, 0, 3'b000, 2'b00, 0), 0);
        chk("R10 wrap to zero sets Z", {15'h0, flag_z}, {15'h0, mz});
        rd(0, "R10 written value check");
    endtask

    task automatic t_out();
        cyc(cw(0, 0, 0, 1, 2'd2, 0, 0, 3'b000, 2'b00, 0), 0);
        chk("R11 released port", out_w, 16'hFFFF);
        cyc(cw(0, 0, 0, 1, 2'd2, 0, 0, 3'b000, 2'b00, 1), 0);
        chk("R11 driven port", out_w, exp_out);
        cyc(cw(0, 0, 0, 0, 0, 0, 0, 3'b000, 2'b00, 1), 0);
        chk("R11 drives zero", out_w, 16'h0000);
    endtask

    task automatic t_rereset();
        do_reset();
        t_reset();
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m[i] = 16'h0000;
        mz = 1'b0;
        mn = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_we_low();
        t_ports();
        t_port_off();
        t_alu();
        t_shift();
        t_shf_write();
        t_flags();
        t_out();
        t_rereset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule